// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Pair

This block joins two independently clocked ports, A and B, through a pair of opposite-direction queues of 18-bit words. One queue carries words from A to B and the other from B to A. On every clock edge of its own domain, each port registers its request inputs. The registered request then either pushes the registered input word into the outgoing queue or pops the incoming queue into the port's output register. A bypass request on a read takes the opposite port's input register instead of the queue. This lets a word cross between the ports without being stored.

Each queue keeps its write-side flags (full, almost-full) in the writer's clock domain and its read-side flags (empty, almost-empty) in the reader's domain. Pointers cross between the domains as Gray code through multi-flop synchronizers, so each flag may lag the far side's activity but never overstates the space or data that is available. Each port loads two threshold registers. One is the almost-full distance of the queue it writes and the other is the almost-empty level of the queue it reads. The tri-state data bus is modelled as a data output plus a drive-enable output.

Top module: `bififo_pair`

## Requirements
- R1: Words written at port A come out of port B in the order written, and words written at B come out of A in the same way. The two queues do not affect each other, including when both ports work in the same cycle.
- R2: Each port registers en, rw (1 = read, 0 = write), byp and din on every edge of its clock. A request sampled at edge N acts at edge N+1, and popped read data appears on dout after edge N+1. A cycle with en low changes no queue and no output register, whatever rw and din hold.
- R3: A write request that reaches a full queue is dropped and does not overwrite stored data.
- R4: A read request that finds its incoming queue empty is dropped, and dout keeps its value.
- R5: drv follows the port's oe input one clock later.
- R6: A read with byp set loads dout from the opposite port's input register, which holds the din sampled at the previous edge of that port. The read does not pop the queue. A write with byp set stores nothing.
- R7: empty is 1 exactly when the reader's view of the stored count is 0. full is 1 exactly when the writer's view equals DEPTH. Once the far side has settled, both views equal the true count.
- R8: almost-empty is 1 when the reader's view of the count is at or below the almost-empty level. The reading port's cfg_ae value is loaded on an edge where cfg_ld is high.
- R9: almost-full is 1 when the writer's view of the count plus the almost-full distance is at least DEPTH. The writing port's cfg_af value is loaded on an edge where cfg_ld is high.
- R10: A synchronous reset on both ports empties both queues, clears dout and drv, and sets all four thresholds to DEF_OFF (default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| en_a | input | 1 | Port A transfer enable |
| rw_a | input | 1 | Port A direction: 1 read, 0 write |
| byp_a | input | 1 | Port A bypass select |
| oe_a | input | 1 | Port A output enable request |
| din_a | input | 18 | Port A write data |
| dout_a | output | 18 | Port A output register |
| drv_a | output | 1 | Port A bus drive enable |
| cfg_ld_a | input | 1 | Load port A thresholds |
| cfg_ae_a | input | 9 | Almost-empty level of the B-to-A queue |
| cfg_af_a | input | 9 | Almost-full distance of the A-to-B queue |
| ab_full | output | 1 | A-to-B queue full (clk_a domain) |
| ab_afull | output | 1 | A-to-B queue almost full (clk_a domain) |
| ba_empty | output | 1 | B-to-A queue empty (clk_a domain) |
| ba_aempty | output | 1 | B-to-A queue almost empty (clk_a domain) |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| en_b | input | 1 | Port B transfer enable |
| rw_b | input | 1 | Port B direction: 1 read, 0 write |
| byp_b | input | 1 | Port B bypass select |
| oe_b | input | 1 | Port B output enable request |
| din_b | input | 18 | Port B write data |
| dout_b | output | 18 | Port B output register |
| drv_b | output | 1 | Port B bus drive enable |
| cfg_ld_b | input | 1 | Load port B thresholds |
| cfg_ae_b | input | 9 | Almost-empty level of the A-to-B queue |
| cfg_af_b | input | 9 | Almost-full distance of the B-to-A queue |
| ba_full | output | 1 | B-to-A queue full (clk_b domain) |
| ba_afull | output | 1 | B-to-A queue almost full (clk_b domain) |
| ab_empty | output | 1 | A-to-B queue empty (clk_b domain) |
| ab_aempty | output | 1 | A-to-B queue almost empty (clk_b domain) |

## Verification
Short bursts in one direction, and simultaneous bursts in both directions, test data order and whether the two queues stay independent. A complete fill of 256 words with one extra write, followed by a complete drain with one extra read, tests overflow and underflow dropping and the full and almost-full edges at counts 247, 248 and 256. Reprogrammed thresholds are probed one word either side of their switching count, so that at-or-below and at-or-above comparisons can be told apart from strict ones. Bypass reads and writes are run with a word already parked in the queue, which shows whether bypass really skips storage. A reset while data is stored shows that thresholds return to their defaults.

// File: rtl/bififo_pkg.sv
package bififo_pkg;
   localparam int unsigned WORD_W = 18;
   typedef logic [WORD_W-1:0] word_t;
   typedef struct packed {
      logic en;
      logic rd;
      logic byp;
   } req_t;
endpackage

// File: rtl/bififo_sync.sv
module bififo_sync #(
   parameter int unsigned W      = 9,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/bififo_queue.sv
module bififo_queue #(
   parameter int unsigned DEPTH   = 256,
   parameter int unsigned W       = 18,
   parameter int unsigned DEF_OFF = 8,
   parameter int unsigned STAGES  = 2,
   localparam int unsigned AW     = $clog2(DEPTH),
   localparam int unsigned PW     = AW + 1
) (
   input  logic          wclk,
   input  logic          wrst,
   input  logic          wr,
   input  logic [W-1:0]  wdata,
   input  logic          af_ld,
   input  logic [PW-1:0] af_off,
   output logic          full,
   output logic          afull,
   input  logic          rclk,
   input  logic          rrst,
   input  logic          rd,
   input  logic          ae_ld,
   input  logic [PW-1:0] ae_off,
   output logic [W-1:0]  rdata,
   output logic          empty,
   output logic          aempty
);
   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wbin, wgray, rbin, rgray;
   logic [PW-1:0] rgray_w, wgray_r, rbin_w, wbin_r;
   logic [PW-1:0] wcnt, rcnt, af_q, ae_q;
   logic          wr_ok, rd_ok;

   function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   // writer domain
   assign wr_ok = wr && !full;

   always_ff @(posedge wclk) begin
      if (wr_ok) mem[wbin[AW-1:0]] <= wdata;
   end

   always_ff @(posedge wclk) begin
      if (wrst) begin
         wbin  <= '0;
         wgray <= '0;
         af_q  <= PW'(DEF_OFF);
      end else begin
         if (wr_ok) begin
            wbin  <= wbin + PW'(1);
            wgray <= to_gray(wbin + PW'(1));
         end
         if (af_ld) af_q <= af_off;
      end
   end

   bififo_sync #(.W(PW), .STAGES(STAGES)) u_r2w (
      .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w)
   );

   assign rbin_w = to_bin(rgray_w);
   assign wcnt   = wbin - rbin_w;
   assign full   = (wcnt == PW'(DEPTH));
   assign afull  = ({1'b0, wcnt} + {1'b0, af_q}) >= (PW+1)'(DEPTH);

   // reader domain
   assign rd_ok = rd && !empty;

   always_ff @(posedge rclk) begin
      if (rrst) begin
         rbin  <= '0;
         rgray <= '0;
         ae_q  <= PW'(DEF_OFF);
      end else begin
         if (rd_ok) begin
            rbin  <= rbin + PW'(1);
            rgray <= to_gray(rbin + PW'(1));
         end
         if (ae_ld) ae_q <= ae_off;
      end
   end

   bififo_sync #(.W(PW), .STAGES(STAGES)) u_w2r (
      .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r)
   );

   assign wbin_r = to_bin(wgray_r);
   assign rcnt   = wbin_r - rbin;
   assign empty  = (rcnt == '0);
   assign aempty = (rcnt <= ae_q);
   assign rdata  = mem[rbin[AW-1:0]];
endmodule

// File: rtl/bififo_port.sv
module bififo_port
   import bififo_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  en,
   input  logic  rd,
   input  logic  byp,
   input  logic  oe,
   input  word_t din,
   input  word_t q_rdata,
   input  logic  q_empty,
   input  word_t byp_word,
   output logic  wr_req,
   output logic  rd_req,
   output word_t din_q,
   output word_t dout,
   output logic  drv
);
   req_t req_q;
   logic oe_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q <= '0;
         oe_q  <= 1'b0;
         din_q <= '0;
         dout  <= '0;
      end else begin
         req_q <= '{en: en, rd: rd, byp: byp};
         oe_q  <= oe;
         din_q <= din;
         if (req_q.en && req_q.rd) begin
            if (req_q.byp)     dout <= byp_word;
            else if (!q_empty) dout <= q_rdata;
         end
      end
   end

   assign wr_req = req_q.en && !req_q.rd && !req_q.byp;
   assign rd_req = req_q.en &&  req_q.rd && !req_q.byp;
   assign drv    = oe_q;
endmodule

// File: rtl/bififo_pair.sv
module bififo_pair
   import bififo_pkg::*;
#(
   parameter int unsigned DEPTH       = 256,
   parameter int unsigned DEF_OFF     = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned PW         = $clog2(DEPTH) + 1
) (
   input  logic          clk_a,
   input  logic          rst_a,
   input  logic          en_a,
   input  logic          rw_a,
   input  logic          byp_a,
   input  logic          oe_a,
   input  word_t         din_a,
   output word_t         dout_a,
   output logic          drv_a,
   input  logic          cfg_ld_a,
   input  logic [PW-1:0] cfg_ae_a,
   input  logic [PW-1:0] cfg_af_a,
   output logic          ab_full,
   output logic          ab_afull,
   output logic          ba_empty,
   output logic          ba_aempty,
   input  logic          clk_b,
   input  logic          rst_b,
   input  logic          en_b,
   input  logic          rw_b,
   input  logic          byp_b,
   input  logic          oe_b,
   input  word_t         din_b,
   output word_t         dout_b,
   output logic          drv_b,
   input  logic          cfg_ld_b,
   input  logic [PW-1:0] cfg_ae_b,
   input  logic [PW-1:0] cfg_af_b,
   output logic          ba_full,
   output logic          ba_afull,
   output logic          ab_empty,
   output logic          ab_aempty
);
   if (!(DEPTH == 256 || DEPTH == 512)) begin : g_bad_depth
      $error("bififo_pair: DEPTH must be 256 or 512");
   end
   if (DEF_OFF > DEPTH) begin : g_bad_off
      $error("bififo_pair: DEF_OFF exceeds DEPTH");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("bififo_pair: SYNC_STAGES must be at least 2");
   end

   // index p: port p, and the queue written by port p
   logic          clk_v [2], rst_v [2], en_v [2], rd_v [2], byp_v [2], oe_v [2];
   logic          ld_v  [2], wreq_v [2], rreq_v [2], drv_v [2];
   logic          full_v [2], afull_v [2], empty_v [2], aempty_v [2];
   logic [PW-1:0] ae_v [2], af_v [2];
   word_t         din_v [2], dinq_v [2], dout_v [2], rdata_v [2];

   assign clk_v[0] = clk_a;    assign clk_v[1] = clk_b;
   assign rst_v[0] = rst_a;    assign rst_v[1] = rst_b;
   assign en_v[0]  = en_a;     assign en_v[1]  = en_b;
   assign rd_v[0]  = rw_a;     assign rd_v[1]  = rw_b;
   assign byp_v[0] = byp_a;    assign byp_v[1] = byp_b;
   assign oe_v[0]  = oe_a;     assign oe_v[1]  = oe_b;
   assign din_v[0] = din_a;    assign din_v[1] = din_b;
   assign ld_v[0]  = cfg_ld_a; assign ld_v[1]  = cfg_ld_b;
   assign ae_v[0]  = cfg_ae_a; assign ae_v[1]  = cfg_ae_b;
   assign af_v[0]  = cfg_af_a; assign af_v[1]  = cfg_af_b;

   for (genvar p = 0; p < 2; p++) begin : g_lane
      bififo_port u_port (
         .clk      (clk_v[p]),
         .rst      (rst_v[p]),
         .en       (en_v[p]),
         .rd       (rd_v[p]),
         .byp      (byp_v[p]),
         .oe       (oe_v[p]),
         .din      (din_v[p]),
         .q_rdata  (rdata_v[1-p]),
         .q_empty  (empty_v[1-p]),
         .byp_word (dinq_v[1-p]),
         .wr_req   (wreq_v[p]),
         .rd_req   (rreq_v[p]),
         .din_q    (dinq_v[p]),
         .dout     (dout_v[p]),
         .drv      (drv_v[p])
      );

      bififo_queue #(
         .DEPTH(DEPTH), .W(WORD_W), .DEF_OFF(DEF_OFF), .STAGES(SYNC_STAGES)
      ) u_queue (
         .wclk   (clk_v[p]),
         .wrst   (rst_v[p]),
         .wr     (wreq_v[p]),
         .wdata  (dinq_v[p]),
         .af_ld  (ld_v[p]),
         .af_off (af_v[p]),
         .full   (full_v[p]),
         .afull  (afull_v[p]),
         .rclk   (clk_v[1-p]),
         .rrst   (rst_v[1-p]),
         .rd     (rreq_v[1-p]),
         .ae_ld  (ld_v[1-p]),
         .ae_off (ae_v[1-p]),
         .rdata  (rdata_v[p]),
         .empty  (empty_v[p]),
         .aempty (aempty_v[p])
      );
   end

   assign dout_a    = dout_v[0];
   assign dout_b    = dout_v[1];
   assign drv_a     = drv_v[0];
   assign drv_b     = drv_v[1];
   assign ab_full   = full_v[0];
   assign ab_afull  = afull_v[0];
   assign ab_empty  = empty_v[0];
   assign ab_aempty = aempty_v[0];
   assign ba_full   = full_v[1];
   assign ba_afull  = afull_v[1];
   assign ba_empty  = empty_v[1];
   assign ba_aempty = aempty_v[1];
endmodule

// File: rtl/bififo_chk.sv
module bififo_chk
   import bififo_pkg::*;
(
   input logic  clk_a,
   input logic  clk_b,
   input logic  rst_a,
   input logic  rst_b,
   input logic  en_a,
   input logic  en_b,
   input logic  oe_a,
   input logic  oe_b,
   input logic  drv_a,
   input logic  drv_b,
   input word_t dout_a,
   input word_t dout_b,
   input logic  ab_full,
   input logic  ab_afull,
   input logic  ab_empty,
   input logic  ab_aempty,
   input logic  ba_full,
   input logic  ba_afull,
   input logic  ba_empty,
   input logic  ba_aempty
);
   // R5: drive enable trails output enable by one edge
   p_drv_a_r5: assert property (@(posedge clk_a) disable iff (rst_a)
      !$past(rst_a) |-> (drv_a == $past(oe_a)));
   p_drv_b_r5: assert property (@(posedge clk_b) disable iff (rst_b)
      !$past(rst_b) |-> (drv_b == $past(oe_b)));

   // R4 and R2: without a request two edges back, the output register holds
   p_hold_a_r4: assert property (@(posedge clk_a) disable iff (rst_a)
      (!$past(rst_a) && !$past(rst_a, 2) && !$past(en_a, 2)) |-> $stable(dout_a));
   p_hold_b_r4: assert property (@(posedge clk_b) disable iff (rst_b)
      (!$past(rst_b) && !$past(rst_b, 2) && !$past(en_b, 2)) |-> $stable(dout_b));

   // R8: an empty queue is always also almost empty
   p_aempty_ab_r8: assert property (@(posedge clk_b) disable iff (rst_b)
      ab_empty |-> ab_aempty);
   p_aempty_ba_r8: assert property (@(posedge clk_a) disable iff (rst_a)
      ba_empty |-> ba_aempty);

   // R9: a full queue is always also almost full
   p_afull_ab_r9: assert property (@(posedge clk_a) disable iff (rst_a)
      ab_full |-> ab_afull);
   p_afull_ba_r9: assert property (@(posedge clk_b) disable iff (rst_b)
      ba_full |-> ba_afull);
endmodule

bind bififo_pair bififo_chk u_chk (.*);

// File: tb/bififo_pair_bench.sv
module bififo_pair_bench;
   import bififo_pkg::*;

   localparam int DEPTH = 256;
   localparam int PW    = 9;
   localparam realtime HALF = 2.5ns;

   logic clk = 1'b0;
   logic rst;
   logic en_a, rw_a, byp_a, oe_a, cfg_ld_a;
   logic en_b, rw_b, byp_b, oe_b, cfg_ld_b;
   word_t din_a, din_b, dout_a, dout_b;
   logic drv_a, drv_b;
   logic [PW-1:0] cfg_ae_a, cfg_af_a, cfg_ae_b, cfg_af_b;
   logic ab_full, ab_afull, ab_empty, ab_aempty;
   logic ba_full, ba_afull, ba_empty, ba_aempty;

   int checks = 0;
   int errors = 0;

   always #HALF clk = ~clk;

   bififo_pair u_bififo_pair (
      .clk_a(clk), .rst_a(rst), .en_a(en_a), .rw_a(rw_a), .byp_a(byp_a),
      .oe_a(oe_a), .din_a(din_a), .dout_a(dout_a), .drv_a(drv_a),
      .cfg_ld_a(cfg_ld_a), .cfg_ae_a(cfg_ae_a), .cfg_af_a(cfg_af_a),
      .ab_full(ab_full), .ab_afull(ab_afull), .ba_empty(ba_empty), .ba_aempty(ba_aempty),
      .clk_b(clk), .rst_b(rst), .en_b(en_b), .rw_b(rw_b), .byp_b(byp_b),
      .oe_b(oe_b), .din_b(din_b), .dout_b(dout_b), .drv_b(drv_b),
      .cfg_ld_b(cfg_ld_b), .cfg_ae_b(cfg_ae_b), .cfg_af_b(cfg_af_b),
      .ba_full(ba_full), .ba_afull(ba_afull), .ab_empty(ab_empty), .ab_aempty(ab_aempty)
   );

   // behavioural reference
   word_t q_ab[$];
   word_t q_ba[$];
   word_t exp_a, exp_b, m_in_a, m_in_b;
   logic  exp_drv_a, exp_drv_b;
   logic  m_en_a, m_rd_a, m_byp_a, m_en_b, m_rd_b, m_byp_b;
   int    af_ab, ae_ab, af_ba, ae_ba;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act %0h exp %0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (rst) begin
         q_ab.delete(); q_ba.delete();
         exp_a = '0; exp_b = '0; m_in_a = '0; m_in_b = '0;
         exp_drv_a = 0; exp_drv_b = 0;
         m_en_a = 0; m_rd_a = 0; m_byp_a = 0;
         m_en_b = 0; m_rd_b = 0; m_byp_b = 0;
         af_ab = 8; ae_ab = 8; af_ba = 8; ae_ba = 8;
      end else begin
         if (m_en_a && m_rd_a) begin
            if (m_byp_a) exp_a = m_in_b;
            else if (q_ba.size() > 0) exp_a = q_ba.pop_front();
         end
         if (m_en_b && m_rd_b) begin
            if (m_byp_b) exp_b = m_in_a;
            else if (q_ab.size() > 0) exp_b = q_ab.pop_front();
         end
         if (m_en_a && !m_rd_a && !m_byp_a && q_ab.size() < DEPTH) q_ab.push_back(m_in_a);
         if (m_en_b && !m_rd_b && !m_byp_b && q_ba.size() < DEPTH) q_ba.push_back(m_in_b);
         if (cfg_ld_a) begin af_ab = int'(cfg_af_a); ae_ba = int'(cfg_ae_a); end
         if (cfg_ld_b) begin af_ba = int'(cfg_af_b); ae_ab = int'(cfg_ae_b); end
         m_en_a = en_a; m_rd_a = rw_a; m_byp_a = byp_a; m_in_a = din_a;
         m_en_b = en_b; m_rd_b = rw_b; m_byp_b = byp_b; m_in_b = din_b;
         exp_drv_a = oe_a; exp_drv_b = oe_b;
      end
   end

   // every-clock comparison of outputs against the reference (R1 R2 R5)
   always @(negedge clk) begin
      if (!rst) begin
         check(dout_a == exp_a, "R1 R2 dout_a", 32'(dout_a), 32'(exp_a));
         check(dout_b == exp_b, "R1 R2 dout_b", 32'(dout_b), 32'(exp_b));
         check(drv_a == exp_drv_a, "R5 drv_a", 32'(drv_a), 32'(exp_drv_a));
         check(drv_b == exp_drv_b, "R5 drv_b", 32'(drv_b), 32'(exp_drv_b));
      end
   end

   task automatic chk_flags(input string tag);
      int ca = q_ab.size();
      int cb = q_ba.size();
      check(ab_empty  == (ca == 0),           {tag, " R7 ab_empty"},  32'(ab_empty),  32'(ca == 0));
      check(ab_full   == (ca == DEPTH),       {tag, " R7 ab_full"},   32'(ab_full),   32'(ca == DEPTH));
      check(ab_aempty == (ca <= ae_ab),       {tag, " R8 ab_aempty"}, 32'(ab_aempty), 32'(ca <= ae_ab));
      check(ab_afull  == (ca + af_ab >= DEPTH), {tag, " R9 ab_afull"}, 32'(ab_afull), 32'(ca + af_ab >= DEPTH));
      check(ba_empty  == (cb == 0),           {tag, " R7 ba_empty"},  32'(ba_empty),  32'(cb == 0));
      check(ba_full   == (cb == DEPTH),       {tag, " R7 ba_full"},   32'(ba_full),   32'(cb == DEPTH));
      check(ba_aempty == (cb <= ae_ba),       {tag, " R8 ba_aempty"}, 32'(ba_aempty), 32'(cb <= ae_ba));
      check(ba_afull  == (cb + af_ba >= DEPTH), {tag, " R9 ba_afull"}, 32'(ba_afull), 32'(cb + af_ba >= DEPTH));
   endtask

   task automatic idle(input int n);
      en_a = 0; en_b = 0; byp_a = 0; byp_b = 0; cfg_ld_a = 0; cfg_ld_b = 0;
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_a_n(input int base, input int n);
      for (int i = 0; i < n; i++) begin
         en_a = 1; rw_a = 0; byp_a = 0; din_a = word_t'(base + i);
         @(negedge clk);
      end
      en_a = 0;
   endtask

   task automatic rd_b_n(input int n);
      for (int i = 0; i < n; i++) begin
         en_b = 1; rw_b = 1; byp_b = 0;
         @(negedge clk);
      end
      en_b = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired act 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1;
      en_a = 0; rw_a = 0; byp_a = 0; oe_a = 0; din_a = '0; cfg_ld_a = 0;
      en_b = 0; rw_b = 0; byp_b = 0; oe_b = 0; din_b = '0; cfg_ld_b = 0;
      cfg_ae_a = '0; cfg_af_a = '0; cfg_ae_b = '0; cfg_af_b = '0;
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);

      // R10: state after reset
      check(dout_a == 0 && dout_b == 0, "R10 dout after reset", 32'({dout_a, dout_b}), 0);
      check(!drv_a && !drv_b, "R10 drv after reset", 32'({drv_a, drv_b}), 0);
      chk_flags("R10 reset");

      // R1: concurrent traffic in both directions
      for (int i = 0; i < 5; i++) begin
         en_a = 1; rw_a = 0; din_a = word_t'(18'h100 + i);
         en_b = (i < 3); rw_b = 0; din_b = word_t'(18'h2A0 + i);
         @(negedge clk);
      end
      idle(8);
      chk_flags("R1 after writes");
      check(!ab_empty && ab_aempty, "R8 five stored", 32'({ab_empty, ab_aempty}), 32'h1);
      for (int i = 0; i < 5; i++) begin
         en_b = 1; rw_b = 1;
         en_a = (i < 3); rw_a = 1;
         @(negedge clk);
      end
      idle(3);
      check(dout_b == 18'h104, "R1 last A-to-B word", 32'(dout_b), 32'h104);
      check(dout_a == 18'h2A2, "R1 last B-to-A word", 32'(dout_a), 32'h2A2);
      idle(6);
      chk_flags("R1 drained");

      // R4: read from an empty queue
      rd_b_n(1);
      idle(3);
      check(dout_b == 18'h104, "R4 dout_b held on empty read", 32'(dout_b), 32'h104);

      // R2: en low, other inputs moving
      for (int i = 0; i < 5; i++) begin
         en_a = 0; rw_a = i[0]; din_a = word_t'(18'h3F000 + i);
         en_b = 0; rw_b = ~i[0]; din_b = word_t'(18'h1F000 + i);
         @(negedge clk);
      end
      idle(8);
      check(ab_empty && ba_empty, "R2 no transfer with en low", 32'({ab_empty, ba_empty}), 32'h3);
      check(dout_b == 18'h104, "R2 dout_b unchanged", 32'(dout_b), 32'h104);

      // R5: output enable to drive enable
      oe_a = 1; @(negedge clk);
      check(drv_a == 1, "R5 drv_a rises", 32'(drv_a), 1);
      oe_a = 0; oe_b = 1; @(negedge clk);
      check(drv_a == 0 && drv_b == 1, "R5 drv follows oe", 32'({drv_a, drv_b}), 32'h1);
      oe_b = 0;

      // R9 R7 R3: fill with default distance 8
      wr_a_n(18'h3000, 247);
      idle(8);
      check(ab_afull == 0, "R9 247 stored not almost full", 32'(ab_afull), 0);
      wr_a_n(18'h3000 + 247, 1);
      idle(2);
      check(ab_afull == 1, "R9 248 stored almost full", 32'(ab_afull), 1);
      wr_a_n(18'h3000 + 248, 8);
      idle(2);
      check(ab_full == 1, "R7 256 stored full", 32'(ab_full), 1);
      wr_a_n(18'h15555, 1);
      idle(8);
      chk_flags("R3 after overflow attempt");
      rd_b_n(257);
      idle(3);
      check(dout_b == 18'h30FF, "R3 last word not overwritten", 32'(dout_b), 32'h30FF);
      idle(6);
      chk_flags("R4 drained after fill");

      // R8 R9: programmed thresholds
      cfg_ld_a = 1; cfg_ae_a = 9'd8;  cfg_af_a = 9'd100;
      cfg_ld_b = 1; cfg_ae_b = 9'd20; cfg_af_b = 9'd8;
      @(negedge clk);
      cfg_ld_a = 0; cfg_ld_b = 0;
      wr_a_n(18'h500, 20);
      idle(8);
      check(ab_aempty == 1, "R8 20 stored at level 20", 32'(ab_aempty), 1);
      wr_a_n(18'h514, 1);
      idle(8);
      check(ab_aempty == 0, "R8 21 stored above level 20", 32'(ab_aempty), 0);
      wr_a_n(18'h515, 134);
      idle(8);
      check(ab_afull == 0, "R9 155 stored with distance 100", 32'(ab_afull), 0);
      wr_a_n(18'h59B, 1);
      idle(8);
      check(ab_afull == 1, "R9 156 stored with distance 100", 32'(ab_afull), 1);
      chk_flags("R9 programmed");
      rd_b_n(156);
      idle(8);
      check(dout_b == 18'h59B, "R1 programmed run last word", 32'(dout_b), 32'h59B);
      chk_flags("R8 programmed drained");

      // R6: bypass
      en_b = 1; rw_b = 0; byp_b = 0; din_b = 18'h0AAAA;
      @(negedge clk);
      en_b = 0; din_b = 18'h12345;
      idle(8);
      en_a = 1; rw_a = 1; byp_a = 1;
      @(negedge clk);
      idle(2);
      check(dout_a == 18'h12345, "R6 bypass read", 32'(dout_a), 32'h12345);
      idle(6);
      check(ba_empty == 0, "R6 bypass leaves queue", 32'(ba_empty), 0);
      en_a = 1; rw_a = 1; byp_a = 0;
      @(negedge clk);
      idle(2);
      check(dout_a == 18'h0AAAA, "R6 stored word after bypass", 32'(dout_a), 32'hAAAA);
      en_b = 1; rw_b = 0; byp_b = 1; din_b = 18'h00777;
      @(negedge clk);
      idle(8);
      check(ba_empty == 1, "R6 bypass write not stored", 32'(ba_empty), 1);
      chk_flags("R6 end");

      // R10: reset with data stored restores default thresholds
      wr_a_n(18'h700, 3);
      idle(2);
      rst = 1;
      repeat (2) @(negedge clk);
      rst = 0;
      @(negedge clk);
      check(dout_a == 0 && dout_b == 0, "R10 dout after second reset", 32'({dout_a, dout_b}), 0);
      chk_flags("R10 second reset");
      wr_a_n(18'h800, 9);
      idle(8);
      check(ab_aempty == 0, "R10 default level 8 restored", 32'(ab_aempty), 0);
      chk_flags("R10 defaults");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule